// File: doc/BRIEF.md
# SEU Sensitive Gate Classifier

This block decides whether one logic gate of a netlist is sensitive to single-event upsets, and so whether a hardening flow should triplicate it. Each input arrives as a signal probability in unsigned Q0.16. The block compares every probability with a programmable threshold to assign an assumed logic level. It then applies the dominant-value rule of the gate type to find which inputs can flip the output. The result is a per-input sensitivity mask and one sensitive bit.

A host flow walks a netlist level by level. For each gate it presents the type code, the packed input probabilities, the number of inputs in use, the threshold, and a flag for gates in the final level. It reads the verdict one clock later. The classification itself is combinational. A single register stage holds the outputs.

Top module: `seu_gate_classifier`

## Requirements
- R1: A lane's assumed level is 1 only when its probability is strictly greater than the threshold. A probability equal to the threshold counts as level 0.
- R2: Gate codes are AND=0, NAND=1, OR=2 and NOR=3. The dominant level is 0 for codes 0 and 1, and 1 for codes 2 and 3.
- R3: For codes 0 to 3, when exactly one in-use lane holds the dominant level, the mask has only that lane's bit set and the sensitive bit is 1.
- R4: For codes 0 to 3, when no in-use lane holds the dominant level, every in-use lane's mask bit is set and the sensitive bit is 1.
- R5: For codes 0 to 3, when two or more in-use lanes hold the dominant level and the gate is not in the last level, the mask is zero and the sensitive bit is 0.
- R6: Codes 4 (XOR), 5 (XNOR), 6 (NOT) and 7 (spare) always give sensitive=1, with every in-use lane's bit set, whatever the probabilities are.
- R7: With the last-level flag set, the gate is sensitive and every in-use lane's bit is set, for any code.
- R8: Lane i occupies probability bits [16*i+15:16*i] and mask bit i. Mask bits at or above the input count are zero. A count above eight acts as eight.
- R9: The outputs change one clock after the inputs are sampled. A synchronous active-high reset clears the sensitive bit and the mask to zero.
- R10: A gate of code 0 to 3 with input count 0 that is not in the last level gives mask 0 and sensitive 0. Any non-zero mask comes with sensitive=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| gate_kind | input | 3 | Gate type code |
| in_count | input | 4 | Number of inputs in use |
| in_prob | input | 128 | Packed Q0.16 input probabilities, lane 0 in the low bits |
| thresh | input | 16 | Threshold probability in Q0.16 |
| last_stage | input | 1 | Gate belongs to the last circuit level |
| sens_q | output | 1 | Registered sensitive verdict |
| mask_q | output | 8 | Registered per-input sensitivity mask |

## Verification
The bench uses the defaults: eight lanes of sixteen-bit probabilities and a four-bit count. Because the count field can hold values up to fifteen, the bench can drive counts above the lane count and so reach the clamp in R8. The sixteen-bit width lets it place a probability exactly on the threshold and one step above it, which tests the strict comparison in R1. The bench also drives every gate code, including the spare one, and probability patterns with zero, one and several dominant lanes.

// File: rtl/seu_cls_pkg.sv
package seu_cls_pkg;

  typedef enum logic [2:0] {
    GK_AND   = 3'd0,
    GK_NAND  = 3'd1,
    GK_OR    = 3'd2,
    GK_NOR   = 3'd3,
    GK_XOR   = 3'd4,
    GK_XNOR  = 3'd5,
    GK_NOT   = 3'd6,
    GK_SPARE = 3'd7
  } gate_kind_e;

  // Gate kinds whose output can be pinned by one input value.
  function automatic logic kind_has_dominance(gate_kind_e k);
    return (k == GK_AND) || (k == GK_NAND) || (k == GK_OR) || (k == GK_NOR);
  endfunction

  // Level that pins the output: 1 for the OR family, 0 for the AND family.
  function automatic logic kind_dominant_level(gate_kind_e k);
    return (k == GK_OR) || (k == GK_NOR);
  endfunction

endpackage

// File: rtl/seu_level_map.sv
module seu_level_map #(
  parameter int N_IN = 8,
  parameter int PW   = 16
) (
  input  logic [N_IN*PW-1:0] prob,
  input  logic [PW-1:0]      thresh,
  output logic [N_IN-1:0]    level
);
  for (genvar g = 0; g < N_IN; g++) begin : g_lane
    // Strictly above threshold reads as 1; a tie reads as 0 (R1).
    assign level[g] = prob[g*PW +: PW] > thresh;
  end
endmodule

// File: rtl/seu_lane_enable.sv
module seu_lane_enable #(
  parameter int N_IN = 8,
  parameter int CW   = 4
) (
  input  logic [CW-1:0]   count,
  output logic [N_IN-1:0] lane_ok
);
  // A count beyond N_IN simply enables every lane (R8).
  for (genvar g = 0; g < N_IN; g++) begin : g_en
    assign lane_ok[g] = int'(count) > g;
  end
endmodule

// File: rtl/seu_dominance.sv
module seu_dominance
  import seu_cls_pkg::*;
#(
  parameter int N_IN = 8
) (
  input  gate_kind_e      kind,
  input  logic            last,
  input  logic [N_IN-1:0] level,
  input  logic [N_IN-1:0] lane_ok,
  output logic [N_IN-1:0] mask,
  output logic            sens,
  output logic            forced
);
  logic [N_IN-1:0] dom_hit;
  logic            dom_lvl;
  int unsigned     dom_cnt;

  always_comb begin
    dom_lvl = kind_dominant_level(kind);
    dom_hit = (dom_lvl ? level : ~level) & lane_ok;
    dom_cnt = $countones(dom_hit);
    forced  = last || !kind_has_dominance(kind);
    if (forced)            mask = lane_ok;
    else if (dom_cnt == 0) mask = lane_ok;
    else if (dom_cnt == 1) mask = dom_hit;
    else                   mask = '0;
    sens = forced || (mask != '0);
  end

  // The mask is empty, a single lane, or all enabled lanes (R3, R4, R5).
  always_comb begin
    assert_mask_shape_R3: assert (mask == '0 || $onehot(mask) || mask == lane_ok);
  end
  // Mask bits never appear on lanes that are not in use (R8).
  always_comb begin
    assert_mask_in_use_R8: assert ((mask & ~lane_ok) == '0);
  end
endmodule

// File: rtl/seu_gate_classifier.sv
module seu_gate_classifier
  import seu_cls_pkg::*;
#(
  parameter int N_IN = 8,
  parameter int PW   = 16,
  parameter int CW   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        gate_kind,
  input  logic [CW-1:0]     in_count,
  input  logic [N_IN*PW-1:0] in_prob,
  input  logic [PW-1:0]     thresh,
  input  logic              last_stage,
  output logic              sens_q,
  output logic [N_IN-1:0]   mask_q
);
  localparam int PROB_BITS = N_IN * PW;

  logic [N_IN-1:0] lane_level;
  logic [N_IN-1:0] lane_ok;
  logic [N_IN-1:0] mask_d;
  logic            sens_d;
  logic            forced_d;
  gate_kind_e      kind;

  assign kind = gate_kind_e'(gate_kind);

  seu_level_map #(.N_IN(N_IN), .PW(PW)) i_level (
    .prob   (in_prob[PROB_BITS-1:0]),
    .thresh (thresh),
    .level  (lane_level)
  );

  seu_lane_enable #(.N_IN(N_IN), .CW(CW)) i_enable (
    .count   (in_count),
    .lane_ok (lane_ok)
  );

  seu_dominance #(.N_IN(N_IN)) i_dom (
    .kind    (kind),
    .last    (last_stage),
    .level   (lane_level),
    .lane_ok (lane_ok),
    .mask    (mask_d),
    .sens    (sens_d),
    .forced  (forced_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sens_q <= 1'b0;
      mask_q <= '0;
    end else begin
      sens_q <= sens_d;
      mask_q <= mask_d;
    end
  end

  // Reset leaves both outputs cleared (R9).
  assert_reset_clear_R9: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!sens_q && mask_q == '0));

  // A last-level gate is reported sensitive one cycle later (R7).
  assert_last_forced_R7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(last_stage)) |-> (sens_q && mask_q == $past(lane_ok)));

  // Gate codes 4 to 7 are always sensitive on every in-use lane (R6).
  assert_xor_class_R6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(gate_kind) >= 3'd4) |-> (sens_q && mask_q == $past(lane_ok)));

  // Any reported lane implies a sensitive gate (R10).
  assert_mask_implies_sens_R10: assert property (@(posedge clk) disable iff (rst)
    (mask_q != '0) |-> sens_q);

  // Registered mask stays within the lanes that were in use (R8).
  assert_mask_bound_R8: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((mask_q & ~$past(lane_ok)) == '0));

  // A forced verdict is never dropped by the register stage (R7).
  assert_forced_carry_R7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(forced_d)) |-> sens_q);
endmodule

// File: tb/test_seu_gate_classifier.sv
module test_seu_gate_classifier;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] P50 = 16'h8000;
  localparam logic [15:0] P70 = 16'hB333;
  localparam logic [15:0] P20 = 16'h3333;
  localparam logic [15:0] P80 = 16'hCCCC;
  localparam logic [15:0] P90 = 16'hE666;

  logic             clk = 1'b0;
  logic             rst;
  logic [2:0]       gate_kind;
  logic [3:0]       in_count;
  logic [7:0][15:0] lanes;
  logic [15:0]      thresh;
  logic             last_stage;
  logic             sens_q;
  logic [7:0]       mask_q;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  seu_gate_classifier i_seu_gate_classifier (
    .clk        (clk),
    .rst        (rst),
    .gate_kind  (gate_kind),
    .in_count   (in_count),
    .in_prob    (lanes),
    .thresh     (thresh),
    .last_stage (last_stage),
    .sens_q     (sens_q),
    .mask_q     (mask_q)
  );

  task automatic check(input string req, input logic s_exp, input logic [7:0] m_exp);
    checks++;
    if (sens_q !== s_exp || mask_q !== m_exp) begin
      fails++;
      $display("FAIL %s: sens=%0b mask=%02h expected sens=%0b mask=%02h",
               req, sens_q, mask_q, s_exp, m_exp);
    end
  endtask

  // Drive at a falling edge, let one rising edge register, sample at the next fall.
  task automatic apply(input logic [2:0] k, input logic [3:0] n, input logic last);
    gate_kind  = k;
    in_count   = n;
    last_stage = last;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic fill(input logic [15:0] v);
    for (int i = 0; i < 8; i++) lanes[i] = v;
  endtask

  task automatic t_reset;
    rst = 1'b1; fill(P90); thresh = P50;
    gate_kind = 3'd4; in_count = 4'd8; last_stage = 1'b1;
    repeat (3) @(negedge clk);
    check("R9 reset clears", 1'b0, 8'h00);
    rst = 1'b0;
  endtask

  task automatic t_or_single;
    fill(P20); thresh = P50;
    lanes[0] = P70; lanes[1] = P20; lanes[2] = P20;
    apply(3'd2, 4'd3, 1'b0);
    check("R3 OR one dominant", 1'b1, 8'h01);
    lanes[2] = P80;
    apply(3'd2, 4'd3, 1'b0);
    check("R5 OR two dominant", 1'b0, 8'h00);
  endtask

  task automatic t_and_family;
    fill(P70); thresh = P50;
    apply(3'd0, 4'd3, 1'b0);
    check("R4 AND none dominant", 1'b1, 8'h07);
    lanes[0] = P70; lanes[1] = P20; lanes[2] = P90;
    apply(3'd1, 4'd3, 1'b0);
    check("R2 NAND dominant is 0", 1'b1, 8'h02);
    fill(P20);
    apply(3'd3, 4'd4, 1'b0);
    check("R2 NOR none dominant", 1'b1, 8'h0F);
    apply(3'd0, 4'd4, 1'b0);
    check("R5 AND all dominant", 1'b0, 8'h00);
  endtask

  task automatic t_tie;
    fill(P90); thresh = P50;
    lanes[0] = P50;
    apply(3'd0, 4'd2, 1'b0);
    check("R1 tie reads as 0", 1'b1, 8'h01);
    lanes[0] = P50 + 16'd1;
    apply(3'd0, 4'd2, 1'b0);
    check("R1 one above reads as 1", 1'b1, 8'h03);
  endtask

  task automatic t_always;
    fill(P20); thresh = P50;
    for (int k = 4; k < 8; k++) begin
      apply(3'(k), 4'd2, 1'b0);
      check("R6 xor-class always sensitive", 1'b1, 8'h03);
    end
    apply(3'd6, 4'd1, 1'b0);
    check("R6 NOT single input", 1'b1, 8'h01);
  endtask

  task automatic t_last;
    fill(P20); thresh = P50;
    apply(3'd0, 4'd3, 1'b1);
    check("R7 last level forces", 1'b1, 8'h07);
    apply(3'd0, 4'd3, 1'b0);
    check("R7 flag cleared back to insensitive", 1'b0, 8'h00);
  endtask

  task automatic t_count;
    fill(P90); thresh = P50;
    lanes[0] = P20; lanes[1] = P20; lanes[2] = P20;
    apply(3'd2, 4'd3, 1'b0);
    check("R8 unused lanes ignored", 1'b1, 8'h07);
    fill(P20);
    apply(3'd2, 4'd12, 1'b0);
    check("R8 count clamps to eight", 1'b1, 8'hFF);
    apply(3'd0, 4'd0, 1'b0);
    check("R10 zero inputs", 1'b0, 8'h00);
  endtask

  task automatic t_latency;
    fill(P70); thresh = P50;
    apply(3'd0, 4'd2, 1'b0);
    gate_kind = 3'd0; in_count = 4'd2; fill(P20);
    check("R9 output holds until edge", 1'b1, 8'h03);
    @(posedge clk); @(negedge clk);
    check("R9 updates after one edge", 1'b0, 8'h00);
    fill(P70);
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R9 reset mid-run", 1'b0, 8'h00);
    rst = 1'b0;
  endtask

  initial begin
    t_reset();
    @(negedge clk);
    t_or_single();
    t_and_family();
    t_tie();
    t_always();
    t_last();
    t_count();
    t_latency();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule